// File: doc/BRIEF.md
# Dual-Port Word Memory with Cross-Port Mailbox Interrupts

This block is a synchronous memory of 4096 words of 16 bits with two ports of equal standing, called left and right. Both ports can read and write any word in the same clock cycle. All controls are active low: a chip select, a write strobe and a read (output) strobe. A read returns its word one clock after the access. When the read strobe is not asserted, the read data register holds its last value.

The two highest words also serve as mailboxes between the ports. The left port posts to the right port through the top word (0xFFF). The right port posts to the left port through the word below it (0xFFE). A write to the peer's mailbox pulls the peer's active-low interrupt output low. A read of that mailbox by the receiving port releases the interrupt. Each port has an active-low busy input. While a port's busy input is low, its mailbox accesses leave the interrupt flags alone. Arbitration that would produce busy is outside this block, so busy is a plain input.

These are plain memory pins with fixed timing and no handshake. Neither port can apply back-pressure.

Top module: `dpram_mailbox`

## Requirements
- R1: While rst_n is low, both interrupt outputs are high and both read data outputs are 0.
- R2: A write (cs_n=0, we_n=0) stores wdata at addr. A read (cs_n=0, we_n=1, oe_n=0) puts the word at addr on rdata after the next clock edge. A read returns the value held before any write in the same cycle. When both ports write the same word in one cycle, the left port's data is kept.
- R3: A left write to 0xFFF with l_busy_n=1 drives r_irq_n low after that clock edge.
- R4: A right read of 0xFFF with r_busy_n=1 returns r_irq_n high after that clock edge.
- R5: A right write to 0xFFE with r_busy_n=1 drives l_irq_n low after that clock edge.
- R6: A left read of 0xFFE with l_busy_n=1 returns l_irq_n high after that clock edge.
- R7: A mailbox access by a port whose busy_n is 0 changes no interrupt flag. The data is still written or read.
- R8: If one port sets a flag in the same cycle that the other port clears it, the flag is set (irq_n low).
- R9: A mailbox word stores data like any other word, and the receiving port reads back what was posted.
- R10: The following leave both interrupt outputs unchanged: reads of ordinary addresses, a read of the peer's mailbox, and a write by a port to its own receive mailbox.
- R11: rdata keeps its value in any cycle in which that port does not read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| l_cs_n | input | 1 | Left chip select, active low |
| l_we_n | input | 1 | Left write strobe, active low |
| l_oe_n | input | 1 | Left read strobe, active low |
| l_addr | input | 12 | Left word address |
| l_wdata | input | 16 | Left write data |
| l_busy_n | input | 1 | Left busy, low blocks left mailbox effects |
| l_rdata | output | 16 | Left read data, registered |
| l_irq_n | output | 1 | Interrupt to left port, active low |
| r_cs_n | input | 1 | Right chip select, active low |
| r_we_n | input | 1 | Right write strobe, active low |
| r_oe_n | input | 1 | Right read strobe, active low |
| r_addr | input | 12 | Right word address |
| r_wdata | input | 16 | Right write data |
| r_busy_n | input | 1 | Right busy, low blocks right mailbox effects |
| r_rdata | output | 16 | Right read data, registered |
| r_irq_n | output | 1 | Interrupt to right port, active low |

## Verification
Directed sequences post and collect through both mailboxes in each direction. They set a flag and clear it with busy low, so a flag that ignores busy is caught. A flag set and cleared in the same cycle separates set-wins from clear-wins priority. Self-mailbox writes and reads of the peer's mailbox show whether the address decode is swapped between ports. Simultaneous writes to one word, and a read of a word being written, tell the left-wins and read-before-write orderings apart. A random phase is then weighted toward the two mailbox words, and every cycle is compared against a behavioural model.

// File: rtl/dpm_pkg.sv
package dpm_pkg;
  localparam int DPM_ADDR_W = 12;
  localparam int DPM_DATA_W = 16;
  localparam int DPM_PORTS  = 2;
  localparam int LEFT       = 0;
  localparam int RIGHT      = 1;

  // Mailbox a port writes to reach its peer: left uses the top word, right the one below.
  function automatic logic [DPM_ADDR_W-1:0] tx_box(input int port);
    logic [DPM_ADDR_W-1:0] top;
    top = '1;
    return (port == LEFT) ? top : top - 1'b1;
  endfunction

  function automatic logic [DPM_ADDR_W-1:0] rx_box(input int port);
    return tx_box(DPM_PORTS - 1 - port);
  endfunction
endpackage

// File: rtl/dpm_port_decode.sv
module dpm_port_decode #(
  parameter int                ADDR_W = 12,
  parameter logic [ADDR_W-1:0] TX_BOX = '1,
  parameter logic [ADDR_W-1:0] RX_BOX = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              busy_n,
  output logic              wr_en,
  output logic              rd_en,
  output logic              post,
  output logic              collect
);
  always_comb begin
    wr_en   = !cs_n && !we_n;
    rd_en   = !cs_n && we_n && !oe_n;
    post    = wr_en && busy_n && (addr == TX_BOX);
    collect = rd_en && busy_n && (addr == RX_BOX);
  end

  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_en, wr_en})); // R2
  AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_n |-> (!post && !collect)); // R7
  AST_SELF_BOX_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == RX_BOX) |-> !post); // R10
endmodule

// File: rtl/dpm_irq_flag.sv
module dpm_irq_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  always_ff @(posedge clk) begin
    if (!rst_n)   irq_n <= 1'b1;
    else if (set) irq_n <= 1'b0;
    else if (clr) irq_n <= 1'b1;
  end

  AST_SET_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n); // R8
  AST_CLR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n); // R4
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq_n)); // R10
endmodule

// File: rtl/dpm_store.sv
module dpm_store #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int PORTS  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PORTS-1:0]  wr_en,
  input  logic [PORTS-1:0]  rd_en,
  input  logic [ADDR_W-1:0] addr  [PORTS],
  input  logic [DATA_W-1:0] wdata [PORTS],
  output logic [DATA_W-1:0] rdata [PORTS]
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Highest port index written first so port 0 (left) lands last and wins.
  always_ff @(posedge clk) begin
    for (int p = PORTS - 1; p >= 0; p--) begin
      if (wr_en[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar g = 0; g < PORTS; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (!rst_n)        rdata[g] <= '0;
      else if (rd_en[g]) rdata[g] <= mem[addr[g]];
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[g] |=> $stable(rdata[g])); // R11
  end
endmodule

// File: rtl/dpram_mailbox.sv
module dpram_mailbox
  import dpm_pkg::*;
#(
  parameter int ADDR_W = DPM_ADDR_W,
  parameter int DATA_W = DPM_DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic [DATA_W-1:0] l_wdata,
  input  logic              l_busy_n,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_irq_n,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  input  logic              r_busy_n,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_irq_n
);
  localparam int NP = DPM_PORTS;
  localparam logic [ADDR_W-1:0] TOP_BOX  = '1;
  localparam logic [ADDR_W-1:0] NEXT_BOX = TOP_BOX - 1'b1;

  logic [NP-1:0]     cs_n, we_n, oe_n, busy_n;
  logic [ADDR_W-1:0] addr  [NP];
  logic [DATA_W-1:0] wdata [NP];
  logic [DATA_W-1:0] rdata [NP];
  logic [NP-1:0]     wr_en, rd_en, post, collect, irq_n;

  always_comb begin
    cs_n   = {r_cs_n, l_cs_n};
    we_n   = {r_we_n, l_we_n};
    oe_n   = {r_oe_n, l_oe_n};
    busy_n = {r_busy_n, l_busy_n};
    addr[LEFT]   = l_addr;
    addr[RIGHT]  = r_addr;
    wdata[LEFT]  = l_wdata;
    wdata[RIGHT] = r_wdata;
  end

  for (genvar g = 0; g < NP; g++) begin : g_port
    localparam logic [ADDR_W-1:0] TX = (g == LEFT) ? TOP_BOX : NEXT_BOX;
    localparam logic [ADDR_W-1:0] RX = (g == LEFT) ? NEXT_BOX : TOP_BOX;

    dpm_port_decode #(.ADDR_W(ADDR_W), .TX_BOX(TX), .RX_BOX(RX)) u_dec (
      .clk(clk), .rst_n(rst_n),
      .cs_n(cs_n[g]), .we_n(we_n[g]), .oe_n(oe_n[g]),
      .addr(addr[g]), .busy_n(busy_n[g]),
      .wr_en(wr_en[g]), .rd_en(rd_en[g]),
      .post(post[g]), .collect(collect[g])
    );

    // Flag g interrupts port g: set by the peer's post, cleared by its own collect.
    dpm_irq_flag u_flag (
      .clk(clk), .rst_n(rst_n),
      .set(post[NP-1-g]), .clr(collect[g]),
      .irq_n(irq_n[g])
    );
  end

  dpm_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORTS(NP)) u_store (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata)
  );

  assign l_rdata = rdata[LEFT];
  assign r_rdata = rdata[RIGHT];
  assign l_irq_n = irq_n[LEFT];
  assign r_irq_n = irq_n[RIGHT];

  AST_L_POST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && !l_we_n && l_busy_n && l_addr == TOP_BOX) |=> !r_irq_n); // R3
  AST_R_POST_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_cs_n && !r_we_n && r_busy_n && r_addr == NEXT_BOX) |=> !l_irq_n); // R5
  AST_L_COLLECT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (!l_cs_n && l_we_n && !l_oe_n && l_busy_n && l_addr == NEXT_BOX &&
     !(!r_cs_n && !r_we_n && r_busy_n && r_addr == NEXT_BOX)) |=> l_irq_n); // R6
  AST_R_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!r_busy_n && !(!l_cs_n && !l_we_n && l_busy_n && l_addr == TOP_BOX))
      |=> $stable(r_irq_n)); // R7
endmodule

// File: tb/dpram_mailbox_bench.sv
module dpram_mailbox_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic l_cs_n, l_we_n, l_oe_n, l_busy_n, r_cs_n, r_we_n, r_oe_n, r_busy_n;
  logic [11:0] l_addr, r_addr;
  logic [15:0] l_wdata, r_wdata, l_rdata, r_rdata;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  dpram_mailbox u_dpram_mailbox (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_busy_n(l_busy_n), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_busy_n(r_busy_n), .r_rdata(r_rdata), .r_irq_n(r_irq_n)
  );

  // ---------------- behavioural reference ----------------
  logic [15:0] mm [int];
  logic [15:0] m_lrd = 16'h0, m_rrd = 16'h0;
  bit m_lvalid = 1, m_rvalid = 1;
  bit m_lirq = 1, m_rirq = 1;
  bit model_on = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lrd = 0; m_rrd = 0; m_lvalid = 1; m_rvalid = 1; m_lirq = 1; m_rirq = 1;
    end else begin
      bit lw, lr, rw, rr, set_r, clr_r, set_l, clr_l;
      lw = !l_cs_n && !l_we_n;
      lr = !l_cs_n && l_we_n && !l_oe_n;
      rw = !r_cs_n && !r_we_n;
      rr = !r_cs_n && r_we_n && !r_oe_n;
      if (lr) begin
        m_lvalid = mm.exists(int'(l_addr));
        if (m_lvalid) m_lrd = mm[int'(l_addr)];
      end
      if (rr) begin
        m_rvalid = mm.exists(int'(r_addr));
        if (m_rvalid) m_rrd = mm[int'(r_addr)];
      end
      if (rw) mm[int'(r_addr)] = r_wdata;
      if (lw) mm[int'(l_addr)] = l_wdata;
      set_r = lw && l_busy_n && l_addr == 12'hFFF;
      clr_r = rr && r_busy_n && r_addr == 12'hFFF;
      set_l = rw && r_busy_n && r_addr == 12'hFFE;
      clr_l = lr && l_busy_n && l_addr == 12'hFFE;
      if (set_r) m_rirq = 0; else if (clr_r) m_rirq = 1;
      if (set_l) m_lirq = 0; else if (clr_l) m_lirq = 1;
    end
  end

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk({15'h0, l_irq_n}, {15'h0, m_lirq}, "R6 model l_irq_n");
      chk({15'h0, r_irq_n}, {15'h0, m_rirq}, "R4 model r_irq_n");
      if (m_lvalid) chk(l_rdata, m_lrd, "R2 model l_rdata");
      if (m_rvalid) chk(r_rdata, m_rrd, "R2 model r_rdata");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic idle();
    l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_busy_n = 1; l_addr = 0; l_wdata = 0;
    r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_busy_n = 1; r_addr = 0; r_wdata = 0;
  endtask
  task automatic cyc();
    @(posedge clk); @(negedge clk);
    idle();
  endtask
  task automatic lwr(input logic [11:0] a, input logic [15:0] d, input bit b);
    l_cs_n = 0; l_we_n = 0; l_oe_n = 1; l_addr = a; l_wdata = d; l_busy_n = b;
  endtask
  task automatic lrd(input logic [11:0] a, input bit b);
    l_cs_n = 0; l_we_n = 1; l_oe_n = 0; l_addr = a; l_busy_n = b;
  endtask
  task automatic rwr(input logic [11:0] a, input logic [15:0] d, input bit b);
    r_cs_n = 0; r_we_n = 0; r_oe_n = 1; r_addr = a; r_wdata = d; r_busy_n = b;
  endtask
  task automatic rrd(input logic [11:0] a, input bit b);
    r_cs_n = 0; r_we_n = 1; r_oe_n = 0; r_addr = a; r_busy_n = b;
  endtask

  task automatic directed();
    // R1 reset state
    chk({15'h0, l_irq_n}, 16'h1, "R1 l_irq_n");
    chk({15'h0, r_irq_n}, 16'h1, "R1 r_irq_n");
    chk(l_rdata, 16'h0, "R1 l_rdata");
    chk(r_rdata, 16'h0, "R1 r_rdata");
    model_on = 1;
    // R2 store and cross-port read
    lwr(12'h005, 16'h1234, 1); cyc();
    rrd(12'h005, 1); cyc();
    chk(r_rdata, 16'h1234, "R2 cross read");
    cyc();
    chk(r_rdata, 16'h1234, "R11 hold");
    // R2 read-before-write
    rrd(12'h005, 1); lwr(12'h005, 16'h7777, 1); cyc();
    chk(r_rdata, 16'h1234, "R2 read old");
    // R2 left wins
    lwr(12'h009, 16'hAAAA, 1); rwr(12'h009, 16'h5555, 1); cyc();
    lrd(12'h009, 1); cyc();
    chk(l_rdata, 16'hAAAA, "R2 left wins");
    // R3 post to right
    lwr(12'hFFF, 16'hBEEF, 1); cyc();
    chk({15'h0, r_irq_n}, 16'h0, "R3 r_irq set");
    chk({15'h0, l_irq_n}, 16'h1, "R3 l_irq untouched");
    // R10 ordinary reads, peer box read
    rrd(12'h100, 1); cyc();
    chk({15'h0, r_irq_n}, 16'h0, "R10 ordinary read");
    lrd(12'hFFF, 1); cyc();
    chk({15'h0, r_irq_n}, 16'h0, "R10 peer box read");
    // R7 busy blocks clear
    rrd(12'hFFF, 0); cyc();
    chk({15'h0, r_irq_n}, 16'h0, "R7 busy clear");
    chk(r_rdata, 16'hBEEF, "R9 box data");
    // R4 clear
    rrd(12'hFFF, 1); cyc();
    chk({15'h0, r_irq_n}, 16'h1, "R4 r_irq clear");
    // R10 self box write
    rwr(12'hFFF, 16'h0101, 1); lwr(12'hFFE, 16'h0202, 1); cyc();
    chk({15'h0, r_irq_n}, 16'h1, "R10 self box r");
    chk({15'h0, l_irq_n}, 16'h1, "R10 self box l");
    // R7 busy blocks set
    lwr(12'hFFF, 16'h3333, 0); cyc();
    chk({15'h0, r_irq_n}, 16'h1, "R7 busy set");
    // R5/R6 right to left
    rwr(12'hFFE, 16'h0C0D, 1); cyc();
    chk({15'h0, l_irq_n}, 16'h0, "R5 l_irq set");
    lrd(12'hFFE, 1); cyc();
    chk({15'h0, l_irq_n}, 16'h1, "R6 l_irq clear");
    chk(l_rdata, 16'h0C0D, "R9 box data l");
    // R8 set wins
    lwr(12'hFFF, 16'h4444, 1); rrd(12'hFFF, 1); cyc();
    chk({15'h0, r_irq_n}, 16'h0, "R8 set wins r");
    rrd(12'hFFF, 1); cyc();
    chk({15'h0, r_irq_n}, 16'h1, "R4 clear after");
    rwr(12'hFFE, 16'h5656, 1); lrd(12'hFFE, 1); cyc();
    chk({15'h0, l_irq_n}, 16'h0, "R8 set wins l");
  endtask

  function automatic logic [11:0] pick();
    int k = $urandom_range(0, 3);
    if (k == 0) return 12'hFFF;
    if (k == 1) return 12'hFFE;
    return 12'($urandom_range(0, 7));
  endfunction

  task automatic random_phase();
    for (int i = 0; i < 400; i++) begin
      int lo = $urandom_range(0, 2);
      int ro = $urandom_range(0, 2);
      bit lb = ($urandom_range(0, 4) != 0);
      bit rb = ($urandom_range(0, 4) != 0);
      if (lo == 1) lwr(pick(), 16'($urandom), lb);
      else if (lo == 2) lrd(pick(), lb);
      if (ro == 1) rwr(pick(), 16'($urandom), rb);
      else if (ro == 2) rrd(pick(), rb);
      cyc();
    end
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    fork
      begin
        directed();
        random_phase();
      end
      begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule